// File: doc/BRIEF.md
# Multichannel Input Debounce and Change Capture

This block takes a bank of raw, active-low digital input pins and turns them into clean per-channel logic levels. Each pin passes through a synchronizer and is inverted, so a pin held at ground reads as one. The result is sampled on a slow periodic tick that is derived from the system clock. A fixed number of clock cycles make up one tick; with a 1 kHz tick rate, one tick is one millisecond. Every channel then runs its own debounce counter, and the filtered level only moves after the sampled level has disagreed with it for that channel's programmed number of consecutive ticks.

A bounce back to the current filtered value before the count completes restarts the count. Every filtered transition on a channel whose capture enable is set records a sticky rise or fall flag. Software clears a flag by writing one to its bit. A channel whose notification enable is set raises its notification request while either of its flags is set.

Software reaches the intervals, the enables, the flags and the filtered levels through a simple single-cycle register port. Writes are strobed and reads are combinational on the same address bus.

Top module: `dio_debounce_capture`

## Requirements
- R1: A sample tick occurs once every TICK_CYCLES clock cycles, and a filtered level changes only in a cycle that carries a tick.
- R2: The path is inverted: a pin held at 0 yields filtered level 1 and a pin held at 1 yields filtered level 0.
- R3: Each pin passes through SYNC_STAGES (at least 2) flip-flops before the debounce logic sees it, and those stages reset to the pin-high value.
- R4: For an interval N ≥ 1, the filtered level takes the new value at the Nth consecutive tick whose sample differs from it. The visible delay is N ticks plus at most one tick period plus the synchronizer stages.
- R5: A tick whose sample equals the filtered level restarts that channel's count from zero.
- R6: Each channel's interval is held in its own register at address 32+channel (low CNT_W bits). Every register resets to DEF_TICKS (10), and a write to one channel's interval leaves the others unchanged.
- R7: An interval of 0 behaves like 1: the filtered level follows the first differing sample with no added delay.
- R8: A filtered 0→1 change sets bit c of the rise register (address 3), and a 1→0 change sets bit c of the fall register (address 4). This happens only if capture enable bit c (address 1) is set in the cycle of the change.
- R9: Rise and fall bits stay set until software writes 1 to that bit. Writing 0 leaves the bit alone. A new event in the same cycle as a clear leaves the bit set.
- R10: notify[c] is high exactly when notify enable bit c (address 2) is set and rise bit c or fall bit c is set.
- R11: Address 0 reads the filtered levels and ignores writes. Addresses 1–4 and 32..32+NCH-1 read back their registers, zero-extended. Every other address reads 0.
- R12: After reset all filtered levels, flags and enables are 0 and no notification is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NCH | Raw active-low input pins |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| level | output | NCH | Filtered, inverted per-channel levels |
| notify | output | NCH | Per-channel notification requests |

## Verification
The bench builds the block with four channels, a tick of five clocks, a five-bit interval counter and the default interval of 10. With these values a full default debounce of ten ticks, and many restarts of it, fit into a few hundred cycles. Channels can be set to intervals 0, 1 and 3 side by side with one left at the default, which puts the degenerate intervals and the independence of the channel registers into the same run. Random pin noise against a behavioural model then reaches bounce lengths on either side of each interval, as well as events that coincide with flag clears and enable changes.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
   localparam int unsigned ADDR_LEVEL   = 0;
   localparam int unsigned ADDR_CAP_EN  = 1;
   localparam int unsigned ADDR_NOTE_EN = 2;
   localparam int unsigned ADDR_RISE    = 3;
   localparam int unsigned ADDR_FALL    = 4;
   localparam int unsigned ADDR_IV_BASE = 32;

   function automatic int unsigned clog2_min1(input int unsigned v);
      int unsigned r;
      r = 1;
      while ((1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/dbc_tick.sv
module dbc_tick #(
   parameter int unsigned TICK_CYCLES = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned TW = dbc_pkg::clog2_min1(TICK_CYCLES + 1);
   localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

   generate
      if (TICK_CYCLES < 1) begin : g_bad
         $error("dbc_tick: TICK_CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                 phase <= phase + 1'b1;
   end

   assign tick = (phase == LAST);

   generate
      if (TICK_CYCLES > 1) begin : g_gap
         assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/dbc_sync.sv
module dbc_sync #(
   parameter int unsigned NCH    = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] d,
   output logic [NCH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dbc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [NCH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '1;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s - 1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbc_filter.sv
module dbc_filter #(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DEF_TICKS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             smp,
   input  logic             iv_we,
   input  logic [CNT_W-1:0] iv_wd,
   output logic [CNT_W-1:0] iv,
   output logic             lvl,
   output logic             rise,
   output logic             fall
);
   generate
      if (DEF_TICKS >= (1 << CNT_W)) begin : g_bad
         $error("dbc_filter: DEF_TICKS does not fit in CNT_W bits");
      end
   endgenerate

   logic [CNT_W-1:0] run;
   logic [CNT_W:0]   run_nx;
   logic             differ, done;

   assign run_nx = {1'b0, run} + 1'b1;
   assign differ = (smp != lvl);
   assign done   = (run_nx >= {1'b0, iv});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) iv <= CNT_W'(DEF_TICKS);
      else if (iv_we) iv <= iv_wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl <= 1'b0;
         run <= '0;
      end else if (tick) begin
         if (!differ) run <= '0;
         else if (done) begin
            lvl <= smp;
            run <= '0;
         end else run <= run_nx[CNT_W-1:0];
      end
   end

   assign rise = tick & differ & done & smp;
   assign fall = tick & differ & done & ~smp;

   assert_level_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl));
   assert_edge_matches_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> lvl);
endmodule

// File: rtl/dbc_capture.sv
module dbc_capture #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] rise_ev,
   input  logic [NCH-1:0] fall_ev,
   input  logic [NCH-1:0] cap_en,
   input  logic [NCH-1:0] clr_rise,
   input  logic [NCH-1:0] clr_fall,
   output logic [NCH-1:0] rise_q,
   output logic [NCH-1:0] fall_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         rise_q <= (rise_q & ~clr_rise) | (rise_ev & cap_en);
         fall_q <= (fall_q & ~clr_fall) | (fall_ev & cap_en);
      end
   end

   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((rise_q & $past(rise_q & ~clr_rise)) == $past(rise_q & ~clr_rise)));
   assert_gated_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((fall_q & ~$past(fall_q) & ~$past(fall_ev & cap_en)) == '0));
endmodule

// File: rtl/dio_debounce_capture.sv
module dio_debounce_capture #(
   parameter int unsigned NCH         = 8,
   parameter int unsigned TICK_CYCLES = 100000,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DEF_TICKS   = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AW          = 6,
   parameter int unsigned DW          = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] pin_raw,
   input  logic           reg_we,
   input  logic [AW-1:0]  reg_addr,
   input  logic [DW-1:0]  reg_wdata,
   output logic [DW-1:0]  reg_rdata,
   output logic [NCH-1:0] level,
   output logic [NCH-1:0] notify
);
   import dbc_pkg::*;

   localparam int unsigned IV_TOP = ADDR_IV_BASE + NCH;

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("dio_debounce_capture: NCH must lie in 1..DW");
      end
      if (CNT_W > DW) begin : g_bad_cnt
         $error("dio_debounce_capture: CNT_W must not exceed DW");
      end
      if ((1 << AW) < IV_TOP) begin : g_bad_aw
         $error("dio_debounce_capture: AW too narrow for the interval registers");
      end
   endgenerate

   logic           tick;
   logic [NCH-1:0] pin_s, smp, rise_ev, fall_ev, rise_q, fall_q;
   logic [NCH-1:0] cap_en, note_en, clr_rise, clr_fall;
   logic [CNT_W-1:0] iv [NCH];

   dbc_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

   dbc_sync #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s));

   assign smp = ~pin_s;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic iv_we;
         assign iv_we = reg_we && (reg_addr == AW'(ADDR_IV_BASE + c));
         dbc_filter #(.CNT_W(CNT_W), .DEF_TICKS(DEF_TICKS)) u_filt (
            .clk(clk), .rst_n(rst_n), .tick(tick), .smp(smp[c]),
            .iv_we(iv_we), .iv_wd(reg_wdata[CNT_W-1:0]), .iv(iv[c]),
            .lvl(level[c]), .rise(rise_ev[c]), .fall(fall_ev[c]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_en  <= '0;
         note_en <= '0;
      end else if (reg_we) begin
         if (reg_addr == AW'(ADDR_CAP_EN))  cap_en  <= reg_wdata[NCH-1:0];
         if (reg_addr == AW'(ADDR_NOTE_EN)) note_en <= reg_wdata[NCH-1:0];
      end
   end

   assign clr_rise = (reg_we && reg_addr == AW'(ADDR_RISE)) ? reg_wdata[NCH-1:0] : '0;
   assign clr_fall = (reg_we && reg_addr == AW'(ADDR_FALL)) ? reg_wdata[NCH-1:0] : '0;

   dbc_capture #(.NCH(NCH)) u_cap (
      .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .fall_ev(fall_ev),
      .cap_en(cap_en), .clr_rise(clr_rise), .clr_fall(clr_fall),
      .rise_q(rise_q), .fall_q(fall_q));

   assign notify = (rise_q | fall_q) & note_en;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(ADDR_LEVEL))        reg_rdata[NCH-1:0] = level;
      else if (reg_addr == AW'(ADDR_CAP_EN))  reg_rdata[NCH-1:0] = cap_en;
      else if (reg_addr == AW'(ADDR_NOTE_EN)) reg_rdata[NCH-1:0] = note_en;
      else if (reg_addr == AW'(ADDR_RISE))    reg_rdata[NCH-1:0] = rise_q;
      else if (reg_addr == AW'(ADDR_FALL))    reg_rdata[NCH-1:0] = fall_q;
      else begin
         for (int c = 0; c < NCH; c++)
            if (reg_addr == AW'(ADDR_IV_BASE + c)) reg_rdata[CNT_W-1:0] = iv[c];
      end
   end

   assert_notify_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (notify & ~(rise_q | fall_q)) == '0);
   assert_reset_quiet_R12: assert property (@(posedge clk)
      $rose(rst_n) |-> (level == '0 && notify == '0));
endmodule

// File: tb/sim_dio_debounce_capture.sv
module sim_dio_debounce_capture;
   localparam int NCH = 4, TPC = 5, CW = 5, DEF = 10, AW = 6, DW = 32;

   logic clk = 0, rst_n = 0;
   logic [NCH-1:0] pin_raw = '1;
   logic reg_we = 0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NCH-1:0] level, notify;

   always #2.5 clk = ~clk;

   dio_debounce_capture #(.NCH(NCH), .TICK_CYCLES(TPC), .CNT_W(CW), .DEF_TICKS(DEF),
      .SYNC_STAGES(2), .AW(AW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .level(level), .notify(notify));

   int n_cmp = 0, n_bad = 0, cyc = 0;
   string tag = "R12";

   // behavioural reference state
   int m_phase;
   bit m_p1 [NCH];
   bit m_p2 [NCH];
   bit m_lvl [NCH];
   int m_run [NCH];
   int m_iv [NCH];
   bit m_rise [NCH];
   bit m_fall [NCH];
   bit m_cap [NCH];
   bit m_note [NCH];

   function automatic logic [DW-1:0] pack(input bit v [NCH]);
      logic [DW-1:0] r = '0;
      for (int c = 0; c < NCH; c++) r[c] = v[c];
      return r;
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_phase = 0;
         for (int c = 0; c < NCH; c++) begin
            m_p1[c] = 1; m_p2[c] = 1; m_lvl[c] = 0; m_run[c] = 0; m_iv[c] = DEF;
            m_rise[c] = 0; m_fall[c] = 0; m_cap[c] = 0; m_note[c] = 0;
         end
      end else begin
         bit tk;
         tk = (m_phase == TPC - 1);
         m_phase = tk ? 0 : m_phase + 1;
         for (int c = 0; c < NCH; c++) begin
            bit s, ev_r, ev_f, clr_r, clr_f;
            int need;
            s = !m_p2[c];
            ev_r = 0; ev_f = 0;
            need = (m_iv[c] < 1) ? 1 : m_iv[c];
            if (tk) begin
               if (s == m_lvl[c]) m_run[c] = 0;
               else if (m_run[c] + 1 >= need) begin
                  m_lvl[c] = s; m_run[c] = 0;
                  if (s) ev_r = 1; else ev_f = 1;
               end else m_run[c] = m_run[c] + 1;
            end
            clr_r = reg_we && reg_addr == 3 && reg_wdata[c];
            clr_f = reg_we && reg_addr == 4 && reg_wdata[c];
            m_rise[c] = (m_rise[c] && !clr_r) || (ev_r && m_cap[c]);
            m_fall[c] = (m_fall[c] && !clr_f) || (ev_f && m_cap[c]);
            if (reg_we && reg_addr == 1) m_cap[c] = reg_wdata[c];
            if (reg_we && reg_addr == 2) m_note[c] = reg_wdata[c];
            if (reg_we && reg_addr == 32 + c) m_iv[c] = int'(reg_wdata[CW-1:0]);
            m_p2[c] = m_p1[c];
            m_p1[c] = pin_raw[c];
         end
      end
   end

   function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
      logic [DW-1:0] r = '0;
      if (a == 0) r = pack(m_lvl);
      else if (a == 1) r = pack(m_cap);
      else if (a == 2) r = pack(m_note);
      else if (a == 3) r = pack(m_rise);
      else if (a == 4) r = pack(m_fall);
      else if (a >= 32 && a < 32 + NCH) r = DW'(m_iv[a - 32]);
      return r;
   endfunction

   task automatic check(input string req, input string what, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [NCH-1:0] exp_n;
         for (int c = 0; c < NCH; c++) exp_n[c] = (m_rise[c] || m_fall[c]) && m_note[c];
         check(tag, "level", DW'(level), pack(m_lvl) & DW'({NCH{1'b1}}));
         check(tag, "notify", DW'(notify), DW'(exp_n));
         check(tag, "rdata", reg_rdata, m_read(reg_addr));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_we = 1; reg_addr = AW'(a); reg_wdata = DW'(d);
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd_check(input int a, input int exp, input string req);
      @(negedge clk);
      reg_addr = AW'(a);
      #1 check(req, "register read", reg_rdata, DW'(exp));
   endtask

   task automatic wait_ticks(input int n);
      repeat (n * TPC) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R12: reset state; R6: default interval
      tag = "R12";
      rd_check(0, 0, "R12");
      rd_check(3, 0, "R12");
      rd_check(1, 0, "R12");
      check("R12", "notify", DW'(notify), '0);
      rd_check(32, DEF, "R6");
      rd_check(35, DEF, "R6");

      // R2, R4, R8, R10: pull pin 0 low with default interval
      tag = "R4";
      wr(1, 'hF);
      wr(2, 'h1);
      @(negedge clk) pin_raw[0] = 0;
      wait_ticks(DEF + 3);
      check("R2", "level bit0", DW'(level[0]), 1);
      rd_check(3, 1, "R8");
      check("R10", "notify", DW'(notify), 1);

      // R9: writing zero keeps the flag, writing one clears it
      tag = "R9";
      wr(3, 0);
      rd_check(3, 1, "R9");
      wr(3, 1);
      rd_check(3, 0, "R9");
      check("R10", "notify after clear", DW'(notify), 0);

      // R11: a write to the level address has no effect; unmapped reads zero
      tag = "R11";
      wr(0, 0);
      rd_check(0, 1, "R11");
      rd_check(9, 0, "R11");

      // R6, R7: per-channel intervals
      tag = "R7";
      wr(33, 0);
      wr(34, 1);
      wr(35, 3);
      rd_check(32, DEF, "R6");
      rd_check(33, 0, "R6");
      @(negedge clk) pin_raw[3:1] = 3'b000;
      wait_ticks(2);
      check("R7", "fast channels", DW'(level[2:1]), 2'b11);
      check("R7", "slow channel still low", DW'(level[3]), 0);
      wait_ticks(3);
      check("R6", "channel 3 after its interval", DW'(level[3]), 1);

      // R5: bounce on channel 3 shorter than its interval
      tag = "R5";
      pin_raw[3] = 1;
      wait_ticks(2);
      pin_raw[3] = 0;
      wait_ticks(2);
      pin_raw[3] = 1;
      wait_ticks(2);
      pin_raw[3] = 0;
      wait_ticks(3);
      check("R5", "bounces filtered", DW'(level[3]), 1);

      // R8: capture disabled for channel 1
      tag = "R8";
      wr(4, 'hF);
      wr(1, 'hD);
      @(negedge clk) pin_raw[1] = 1;
      wait_ticks(3);
      check("R8", "level bit1", DW'(level[1]), 0);
      rd_check(4, 0, "R8");

      // R1, R3: random noise checked cycle by cycle against the model
      tag = "R3";
      wr(1, 'hF);
      wr(2, 'hA);
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if ($urandom_range(0, 5) == 0) pin_raw[$urandom_range(0, NCH - 1)] ^= 1'b1;
         reg_addr = AW'($urandom_range(0, 5));
         if (i % 400 == 399) begin
            reg_we = 1; reg_addr = AW'($urandom_range(3, 4)); reg_wdata = DW'($urandom_range(0, 15));
            tag = "R9";
         end else begin
            reg_we = 0;
            tag = (i % 2 == 0) ? "R1" : "R3";
         end
      end
      @(negedge clk) reg_we = 0;
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule